// File: doc/BRIEF.md
# Serial Configuration EEPROM Reader with Address-Width Discovery

This block fetches a small configuration area from a three-wire serial EEPROM right after reset, without being told how many address bits the memory uses. It drives chip select, serial clock and serial data into the memory, and samples the memory's serial data output. The first access is a sizing read. The block sends the read opcode followed by a zero address of up to `MAX_ABITS` bits. It stops sending address bits as soon as the memory answers with its leading zero bit, and it derives the address width from how many bits had been sent by then.

With the width known, the block reads words `0` to `NWORDS-1` in ascending order. It keeps every word in a register array and adds up all their bytes modulo 256. A sum of zero marks the area as valid. Three consecutive words, taken from the highest one downwards, form a 48-bit station address. If no leading zero appears within `MAX_ABITS` address bits, the block reports that no memory is present and does no word reads. In every case `done_o` rises once the work is over and stays high until the next reset.

Top module: `eeprd_top`

## Requirements
- R1: Each access raises `ee_cs_o` and then sends the opcode bits 1, 1, 0 in that order, followed by the address most significant bit first. Each bit is presented on `ee_di_o` while `ee_sck_o` is low and clocked by one high pulse of `ee_sck_o`. `ee_di_o` never changes while `ee_sck_o` is high.
- R2: The first access after reset sends a zero address of at most `MAX_ABITS` bits and samples `ee_do_i` after each address pulse. At the first 0 it stops sending address bits. `awidth_o` then reports `MAX_ABITS` minus the index of the address bit that was last sent, counted from 0 at the least significant end.
- R3: After the sizing access, the block reads words 0 to `NWORDS-1` in ascending order, each with exactly `awidth_o` address bits. A present memory therefore sees `NWORDS+1` accesses, with addresses 0, 0, 1, …, `NWORDS-1`, and opcode bits 10 after the start bit.
- R4: After the address, 16 data bits are clocked in most significant bit first, each sampled at the end of the high phase of `ee_sck_o`. Word i appears on `words_o[16*i+15:16*i]`.
- R5: `csum_ok_o` is 1 exactly when the low and high bytes of all `NWORDS` words add to 0 modulo 256, and it is 0 otherwise.
- R6: `station_o[47:40]` is the low byte of word `MAC_TOP`, `[39:32]` its high byte, `[31:24]` and `[23:16]` the low and high bytes of word `MAC_TOP-1`, and `[15:8]` and `[7:0]` those of word `MAC_TOP-2`.
- R7: Between accesses and after completion, `ee_cs_o`, `ee_sck_o` and `ee_di_o` are all 0, and `ee_sck_o` is never high while `ee_cs_o` is low.
- R8: If `ee_do_i` stays 1 for all `MAX_ABITS` sizing address bits, `absent_o` goes to 1 together with `done_o`. `awidth_o` then stays 0, `csum_ok_o` stays 0, `words_o` stays all zero and no further access is made.
- R9: During reset all outputs are 0. `done_o` rises once at the end of the sequence and stays at 1 until reset, and no access starts after it.
- R10: Every high pulse of `ee_sck_o` lasts exactly `HALF_CLKS` clock cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ee_cs_o | output | 1 | Chip select to the EEPROM, active high |
| ee_sck_o | output | 1 | Serial clock to the EEPROM |
| ee_di_o | output | 1 | Serial data into the EEPROM |
| ee_do_i | input | 1 | Serial data from the EEPROM (idles high) |
| words_o | output | NWORDS*16 | Words read, word i in bits 16*i+15:16*i |
| csum_ok_o | output | 1 | Byte sum of all words is zero |
| absent_o | output | 1 | No leading zero seen during sizing |
| station_o | output | MAC_NWORDS*16 | Station address assembled from the top words |
| awidth_o | output | $clog2(MAX_ABITS+1) | Detected address width in bits |
| done_o | output | 1 | Sequence finished, held until reset |

## Verification
All results become valid at the clock edge that raises `done_o`, and they stay fixed from then on. The bench polls `done_o` on falling clock edges and reads the results one falling edge after it sees `done_o` high, so no result is read while it may still change. Serial timing is checked separately. The bench's memory model answers on the rising edge of `ee_sck_o`, and the design samples `ee_do_i` after a synchronizer of `SYNC_STAGES` flops at the end of a high phase that lasts `HALF_CLKS` cycles, so the bench clock uses `HALF_CLKS` larger than `SYNC_STAGES`. The width of each high pulse is measured on falling clock edges and compared with `HALF_CLKS`.

// File: rtl/eeprd_pkg.sv
package eeprd_pkg;

   localparam int WORD_W = 16;
   localparam logic [2:0] RD_OPCODE = 3'b110;

   typedef enum logic [2:0] {
      X_IDLE,
      X_SEL,
      X_LO,
      X_HI,
      X_END
   } xfer_st_t;

   typedef enum logic [1:0] {
      PH_OPC,
      PH_ADR,
      PH_DAT
   } xfer_ph_t;

   typedef enum logic [1:0] {
      Q_BOOT,
      Q_SIZE,
      Q_READ,
      Q_FIN
   } seq_st_t;

endpackage

// File: rtl/eeprd_tick.sv
module eeprd_tick #(
   parameter int HALF_CLKS = 50
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic run_i,
   output logic tick_o
);
   localparam int CW = (HALF_CLKS > 1) ? $clog2(HALF_CLKS) : 1;
   localparam logic [CW-1:0] LAST = CW'(HALF_CLKS - 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (!run_i || cnt_q == LAST) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign tick_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/eeprd_sync.sv
module eeprd_sync #(
   parameter int STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic q_o
);
   generate
      if (STAGES == 0) begin : g_pass
         assign q_o = d_i;
      end else begin : g_flops
         logic [STAGES-1:0] sh_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               sh_q <= '1;
            end else if (STAGES == 1) begin
               sh_q[0] <= d_i;
            end else begin
               sh_q <= {sh_q[STAGES-2:0], d_i};
            end
         end
         assign q_o = sh_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/eeprd_xfer.sv
module eeprd_xfer
   import eeprd_pkg::*;
#(
   parameter int MAX_ABITS = 8,
   parameter int AWW       = $clog2(MAX_ABITS + 1)
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 tick_i,
   input  logic                 start_i,
   input  logic                 sizing_i,
   input  logic [AWW-1:0]       width_i,
   input  logic [MAX_ABITS-1:0] addr_i,
   input  logic                 do_i,
   output logic                 busy_o,
   output logic                 cs_o,
   output logic                 sck_o,
   output logic                 di_o,
   output logic                 fin_o,
   output logic                 nodummy_o,
   output logic [AWW-1:0]       fwidth_o,
   output logic [WORD_W-1:0]    data_o
);
   localparam int OUTW = 3 + MAX_ABITS;
   localparam int CMAX = (MAX_ABITS > WORD_W) ? MAX_ABITS : WORD_W;
   localparam int CNTW = $clog2(CMAX);

   xfer_st_t          st_q;
   xfer_ph_t          ph_q;
   logic [OUTW-1:0]   osh_q;
   logic [CNTW-1:0]   cnt_q;
   logic              sizing_q;
   logic [AWW-1:0]    wu_q;
   logic [AWW-1:0]    wu;
   logic [AWW-1:0]    sh_amt;

   assign wu     = sizing_i ? AWW'(MAX_ABITS) : width_i;
   assign sh_amt = AWW'(MAX_ABITS) - wu;
   assign busy_o = (st_q != X_IDLE);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q      <= X_IDLE;
         ph_q      <= PH_OPC;
         osh_q     <= '0;
         cnt_q     <= '0;
         sizing_q  <= 1'b0;
         wu_q      <= '0;
         cs_o      <= 1'b0;
         sck_o     <= 1'b0;
         di_o      <= 1'b0;
         fin_o     <= 1'b0;
         nodummy_o <= 1'b0;
         fwidth_o  <= '0;
         data_o    <= '0;
      end else begin
         fin_o <= 1'b0;
         case (st_q)
            X_IDLE: begin
               if (start_i) begin
                  cs_o      <= 1'b1;
                  st_q      <= X_SEL;
                  ph_q      <= PH_OPC;
                  osh_q     <= {RD_OPCODE, addr_i << sh_amt};
                  cnt_q     <= CNTW'(2);
                  sizing_q  <= sizing_i;
                  wu_q      <= wu;
                  nodummy_o <= 1'b0;
                  data_o    <= '0;
               end
            end
            X_SEL: begin
               if (tick_i) begin
                  di_o  <= osh_q[OUTW-1];
                  osh_q <= {osh_q[OUTW-2:0], 1'b0};
                  st_q  <= X_LO;
               end
            end
            X_LO: begin
               if (tick_i) begin
                  sck_o <= 1'b1;
                  st_q  <= X_HI;
               end
            end
            X_HI: begin
               if (tick_i) begin
                  sck_o <= 1'b0;
                  st_q  <= X_LO;
                  case (ph_q)
                     PH_OPC: begin
                        di_o  <= osh_q[OUTW-1];
                        osh_q <= {osh_q[OUTW-2:0], 1'b0};
                        if (cnt_q == '0) begin
                           ph_q  <= PH_ADR;
                           cnt_q <= CNTW'(wu_q) - 1'b1;
                        end else begin
                           cnt_q <= cnt_q - 1'b1;
                        end
                     end
                     PH_ADR: begin
                        if (sizing_q && !do_i) begin
                           fwidth_o <= AWW'(MAX_ABITS) - AWW'(cnt_q);
                           ph_q     <= PH_DAT;
                           cnt_q    <= CNTW'(WORD_W - 1);
                           di_o     <= 1'b0;
                        end else if (cnt_q == '0) begin
                           di_o <= 1'b0;
                           if (sizing_q) begin
                              nodummy_o <= 1'b1;
                              cs_o      <= 1'b0;
                              st_q      <= X_END;
                           end else begin
                              ph_q  <= PH_DAT;
                              cnt_q <= CNTW'(WORD_W - 1);
                           end
                        end else begin
                           cnt_q <= cnt_q - 1'b1;
                           di_o  <= osh_q[OUTW-1];
                           osh_q <= {osh_q[OUTW-2:0], 1'b0};
                        end
                     end
                     default: begin
                        data_o <= {data_o[WORD_W-2:0], do_i};
                        if (cnt_q == '0) begin
                           cs_o <= 1'b0;
                           di_o <= 1'b0;
                           st_q <= X_END;
                        end else begin
                           cnt_q <= cnt_q - 1'b1;
                        end
                     end
                  endcase
               end
            end
            X_END: begin
               if (tick_i) begin
                  st_q  <= X_IDLE;
                  fin_o <= 1'b1;
               end
            end
            default: st_q <= X_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/eeprd_seq.sv
module eeprd_seq
   import eeprd_pkg::*;
#(
   parameter int MAX_ABITS = 8,
   parameter int NWORDS    = 14,
   parameter int AWW       = $clog2(MAX_ABITS + 1)
) (
   input  logic                     clk_i,
   input  logic                     rst_ni,
   input  logic                     fin_i,
   input  logic                     nodummy_i,
   input  logic [AWW-1:0]           fwidth_i,
   input  logic [WORD_W-1:0]        data_i,
   output logic                     start_o,
   output logic                     sizing_o,
   output logic [AWW-1:0]           width_o,
   output logic [MAX_ABITS-1:0]     addr_o,
   output logic [NWORDS*WORD_W-1:0] words_o,
   output logic                     csum_ok_o,
   output logic                     absent_o,
   output logic                     done_o
);
   localparam int IW = (NWORDS > 1) ? $clog2(NWORDS) : 1;
   localparam logic [IW-1:0] LAST_IDX = IW'(NWORDS - 1);

   seq_st_t     st_q;
   logic [IW-1:0] idx_q;
   logic [7:0]  sum_q;
   logic [7:0]  sum_nxt;
   logic        store;

   assign sum_nxt = sum_q + data_i[7:0] + data_i[15:8];
   assign store   = (st_q == Q_READ) && fin_i;
   assign addr_o  = MAX_ABITS'(idx_q);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q      <= Q_BOOT;
         idx_q     <= '0;
         sum_q     <= '0;
         start_o   <= 1'b0;
         sizing_o  <= 1'b0;
         width_o   <= '0;
         csum_ok_o <= 1'b0;
         absent_o  <= 1'b0;
         done_o    <= 1'b0;
      end else begin
         start_o <= 1'b0;
         case (st_q)
            Q_BOOT: begin
               start_o  <= 1'b1;
               sizing_o <= 1'b1;
               st_q     <= Q_SIZE;
            end
            Q_SIZE: begin
               if (fin_i) begin
                  if (nodummy_i) begin
                     absent_o <= 1'b1;
                     done_o   <= 1'b1;
                     st_q     <= Q_FIN;
                  end else begin
                     width_o  <= fwidth_i;
                     sizing_o <= 1'b0;
                     idx_q    <= '0;
                     start_o  <= 1'b1;
                     st_q     <= Q_READ;
                  end
               end
            end
            Q_READ: begin
               if (fin_i) begin
                  sum_q <= sum_nxt;
                  if (idx_q == LAST_IDX) begin
                     csum_ok_o <= (sum_nxt == 8'd0);
                     done_o    <= 1'b1;
                     st_q      <= Q_FIN;
                  end else begin
                     idx_q   <= idx_q + 1'b1;
                     start_o <= 1'b1;
                  end
               end
            end
            default: st_q <= Q_FIN;
         endcase
      end
   end

   generate
      for (genvar g = 0; g < NWORDS; g++) begin : g_word
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               words_o[g*WORD_W +: WORD_W] <= '0;
            end else if (store && idx_q == IW'(g)) begin
               words_o[g*WORD_W +: WORD_W] <= data_i;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/eeprd_top.sv
module eeprd_top
   import eeprd_pkg::*;
#(
   parameter int HALF_CLKS   = 50,
   parameter int SYNC_STAGES = 2,
   parameter int MAX_ABITS   = 8,
   parameter int NWORDS      = 14,
   parameter int MAC_TOP     = 12,
   parameter int MAC_NWORDS  = 3
) (
   input  logic                             clk_i,
   input  logic                             rst_ni,
   output logic                             ee_cs_o,
   output logic                             ee_sck_o,
   output logic                             ee_di_o,
   input  logic                             ee_do_i,
   output logic [NWORDS*WORD_W-1:0]         words_o,
   output logic                             csum_ok_o,
   output logic                             absent_o,
   output logic [MAC_NWORDS*WORD_W-1:0]     station_o,
   output logic [$clog2(MAX_ABITS+1)-1:0]   awidth_o,
   output logic                             done_o
);
   localparam int AWW = $clog2(MAX_ABITS + 1);
   localparam int SW  = MAC_NWORDS * WORD_W;

   generate
      if (HALF_CLKS < 1) begin : g_bad_half
         $error("HALF_CLKS must be at least 1");
      end
      if (HALF_CLKS <= SYNC_STAGES) begin : g_bad_sync
         $error("HALF_CLKS must exceed SYNC_STAGES");
      end
      if (MAX_ABITS < 1) begin : g_bad_abits
         $error("MAX_ABITS must be at least 1");
      end
      if (NWORDS < 1 || NWORDS > (1 << MAX_ABITS)) begin : g_bad_nwords
         $error("NWORDS must fit the address space");
      end
      if (MAC_TOP >= NWORDS || MAC_TOP + 1 < MAC_NWORDS) begin : g_bad_mac
         $error("station words must lie inside the read area");
      end
   endgenerate

   logic                 tick;
   logic                 busy;
   logic                 do_s;
   logic                 start;
   logic                 sizing;
   logic [AWW-1:0]       width;
   logic [MAX_ABITS-1:0] addr;
   logic                 fin;
   logic                 nodummy;
   logic [AWW-1:0]       fwidth;
   logic [WORD_W-1:0]    rdata;

   eeprd_tick #(.HALF_CLKS(HALF_CLKS)) u_tick (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .run_i  (busy),
      .tick_o (tick)
   );

   eeprd_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (ee_do_i),
      .q_o    (do_s)
   );

   eeprd_xfer #(.MAX_ABITS(MAX_ABITS), .AWW(AWW)) u_xfer (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .tick_i    (tick),
      .start_i   (start),
      .sizing_i  (sizing),
      .width_i   (width),
      .addr_i    (addr),
      .do_i      (do_s),
      .busy_o    (busy),
      .cs_o      (ee_cs_o),
      .sck_o     (ee_sck_o),
      .di_o      (ee_di_o),
      .fin_o     (fin),
      .nodummy_o (nodummy),
      .fwidth_o  (fwidth),
      .data_o    (rdata)
   );

   eeprd_seq #(.MAX_ABITS(MAX_ABITS), .NWORDS(NWORDS), .AWW(AWW)) u_seq (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .fin_i     (fin),
      .nodummy_i (nodummy),
      .fwidth_i  (fwidth),
      .data_i    (rdata),
      .start_o   (start),
      .sizing_o  (sizing),
      .width_o   (width),
      .addr_o    (addr),
      .words_o   (words_o),
      .csum_ok_o (csum_ok_o),
      .absent_o  (absent_o),
      .done_o    (done_o)
   );

   assign awidth_o = width;

   generate
      for (genvar j = 0; j < MAC_NWORDS; j++) begin : g_station
         localparam int WI = MAC_TOP - j;
         assign station_o[SW-1-WORD_W*j -: 8] = words_o[WORD_W*WI +: 8];
         assign station_o[SW-9-WORD_W*j -: 8] = words_o[WORD_W*WI+8 +: 8];
      end
   endgenerate
endmodule

// File: rtl/eeprd_chk.sv
module eeprd_chk #(
   parameter int MAX_ABITS = 8,
   parameter int AWW       = 4
) (
   input logic           clk_i,
   input logic           rst_ni,
   input logic           ee_cs_o,
   input logic           ee_sck_o,
   input logic           ee_di_o,
   input logic           csum_ok_o,
   input logic           absent_o,
   input logic [AWW-1:0] awidth_o,
   input logic           done_o
);
   // R7
   sck_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ee_cs_o |-> !ee_sck_o);

   // R1
   di_setup_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(ee_di_o) |-> !ee_sck_o);

   // R9
   done_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> done_o);

   // R5
   csum_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      csum_ok_o |-> (done_o && !absent_o));

   // R8
   absent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      absent_o |-> (done_o && awidth_o == '0 && !csum_ok_o));

   // R7
   quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> (!ee_cs_o && !ee_sck_o && !ee_di_o));

   // R2
   width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_o && !absent_o) |-> (awidth_o != '0 && awidth_o <= AWW'(MAX_ABITS)));
endmodule

bind eeprd_top eeprd_chk #(
   .MAX_ABITS (MAX_ABITS),
   .AWW       ($clog2(MAX_ABITS + 1))
) u_chk (
   .clk_i     (clk_i),
   .rst_ni    (rst_ni),
   .ee_cs_o   (ee_cs_o),
   .ee_sck_o  (ee_sck_o),
   .ee_di_o   (ee_di_o),
   .csum_ok_o (csum_ok_o),
   .absent_o  (absent_o),
   .awidth_o  (awidth_o),
   .done_o    (done_o)
);

// File: tb/sim_eeprd_top.sv
module sim_eeprd_top;
   localparam int HALF   = 4;
   localparam int NW     = 14;
   localparam int MTOP   = 12;
   localparam int LIMIT  = 20000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs, sck, di;
   logic ee_do = 1'b1;
   logic [NW*16-1:0] words;
   logic csum_ok, absent, done;
   logic [47:0] station;
   logic [3:0] awidth;

   int checks = 0;
   int errors = 0;

   logic [15:0] mem [0:255];
   int  m_aw = 6;
   bit  m_present = 1'b1;
   int  m_st = 0;
   int  m_cnt = 0;
   logic [15:0] m_sh = '0;
   logic [15:0] m_word = '0;
   int  log_n = 0;
   int  log_addr [0:31];
   int  log_op [0:31];
   int  cs_rises = 0;
   int  hcnt = 0;
   int  bad_pulse = 0;

   always #10 clk = ~clk;

   eeprd_top #(.HALF_CLKS(HALF), .SYNC_STAGES(2)) u0 (
      .clk_i     (clk),
      .rst_ni    (rst_n),
      .ee_cs_o   (cs),
      .ee_sck_o  (sck),
      .ee_di_o   (di),
      .ee_do_i   (ee_do),
      .words_o   (words),
      .csum_ok_o (csum_ok),
      .absent_o  (absent),
      .station_o (station),
      .awidth_o  (awidth),
      .done_o    (done)
   );

   // serial memory model: answers on the rising serial clock
   always @(posedge sck or negedge cs) begin
      int a;
      if (!cs) begin
         m_st = 0; m_cnt = 0; m_sh = '0;
         ee_do <= 1'b1;
      end else if (!m_present) begin
         ee_do <= 1'b1;
      end else begin
         case (m_st)
            0: if (di) begin m_st = 1; m_cnt = 0; m_sh = '0; end
            1: begin
               m_sh = {m_sh[14:0], di}; m_cnt++;
               if (m_cnt == 2) begin m_st = 2; m_cnt = 0; end
            end
            2: begin
               m_sh = {m_sh[14:0], di}; m_cnt++;
               if (m_cnt == m_aw) begin
                  a = int'(m_sh) & ((1 << m_aw) - 1);
                  if (log_n < 32) begin
                     log_addr[log_n] = a;
                     log_op[log_n] = (int'(m_sh) >> m_aw) & 3;
                  end
                  log_n++;
                  m_word = mem[a];
                  m_st = 3; m_cnt = 0;
                  ee_do <= 1'b0;
               end
            end
            default: begin
               ee_do <= m_word[15-m_cnt];
               m_cnt = (m_cnt + 1) % 16;
            end
         endcase
      end
   end

   always @(posedge cs) cs_rises++;

   always @(negedge clk) begin
      if (sck) hcnt++;
      else if (hcnt != 0) begin
         if (hcnt != HALF) bad_pulse++;
         hcnt = 0;
      end
   end

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   function automatic logic [7:0] byte_sum(input int n);
      logic [7:0] s = 8'd0;
      for (int i = 0; i < n; i++) s = s + mem[i][7:0] + mem[i][15:8];
      return s;
   endfunction

   function automatic logic [47:0] exp_station();
      logic [47:0] e = '0;
      for (int j = 0; j < 3; j++) begin
         e[47-16*j -: 8] = mem[MTOP-j][7:0];
         e[39-16*j -: 8] = mem[MTOP-j][15:8];
      end
      return e;
   endfunction

   task automatic run_case(input int aw, input bit present, input bit bad);
      logic [7:0] s, hi, lo;
      int t;
      int rises;
      m_aw = aw;
      m_present = present;
      for (int i = 0; i < 256; i++) mem[i] = 16'($urandom);
      s  = byte_sum(NW - 1);
      hi = 8'($urandom);
      lo = 8'(8'd0 - s - hi);
      if (bad) lo = lo + 8'd1;
      mem[NW-1] = {hi, lo};

      rst_n = 1'b0;
      repeat (4) @(negedge clk);
      log_n = 0; cs_rises = 0; bad_pulse = 0;
      // R9 reset state
      chk({cs, sck, di, done, absent, csum_ok} == 6'b0 && awidth == 0 && words == '0,
          "R9", "reset state", {cs, sck, di, done, absent, csum_ok}, 0);
      rst_n = 1'b1;

      t = 0;
      while (!done && t < LIMIT) begin @(negedge clk); t++; end
      if (!done) begin
         chk(1'b0, "R9", "watchdog: done never rose", t, LIMIT);
         return;
      end
      @(negedge clk);

      if (present) begin
         chk(absent == 1'b0, "R8", "absent flag on present memory", absent, 0);
         chk(awidth == 4'(aw), "R2", "detected width", awidth, aw);
         for (int i = 0; i < NW; i++)
            chk(words[16*i +: 16] == mem[i], "R4", $sformatf("word %0d", i),
                words[16*i +: 16], mem[i]);
         chk(csum_ok == !bad, "R5", "checksum flag", csum_ok, !bad);
         chk(station == exp_station(), "R6", "station address", station, exp_station());
         chk(cs_rises == NW + 1 && log_n == NW + 1, "R3", "access count", log_n, NW + 1);
         for (int k = 0; k < NW + 1 && k < log_n; k++) begin
            chk(log_op[k] == 2, "R1", $sformatf("opcode of access %0d", k), log_op[k], 2);
            chk(log_addr[k] == ((k == 0) ? 0 : k - 1), "R3",
                $sformatf("address of access %0d", k), log_addr[k], (k == 0) ? 0 : k - 1);
         end
      end else begin
         chk(absent == 1'b1, "R8", "absent flag", absent, 1);
         chk(awidth == 0 && csum_ok == 0 && words == '0, "R8", "outputs when absent",
             {awidth, csum_ok}, 0);
         chk(cs_rises == 1, "R8", "single access when absent", cs_rises, 1);
      end
      chk({cs, sck, di} == 3'b0, "R7", "serial pins idle after done", {cs, sck, di}, 0);
      chk(bad_pulse == 0, "R10", "clock high pulse width", bad_pulse, 0);
      rises = cs_rises;
      repeat (40) @(negedge clk);
      chk(done == 1'b1 && cs_rises == rises, "R9", "done held, no new access",
          {done, 8'(cs_rises)}, {1'b1, 8'(rises)});
   endtask

   initial begin
      void'($urandom(32'h5eed_1234));
      run_case(6, 1'b1, 1'b0);
      run_case(8, 1'b1, 1'b0);
      run_case(4, 1'b1, 1'b0);
      run_case(7, 1'b1, 1'b1);
      run_case(6, 1'b0, 1'b0);
      for (int r = 0; r < 4; r++)
         run_case(int'($urandom_range(4, 8)), 1'b1, 1'($urandom % 2));
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule